// File: doc/BRIEF.md
# Multi-Direction Bivariate Projection Unit

This block takes a stream of complex samples, one per clock, each carried as a signed 16-bit real part and a signed 16-bit imaginary part. From each sample it forms a fixed number of real-valued projections onto directions spread evenly around the unit circle. Each projection is the real part of the sample after a rotation by minus its direction angle, so lane k delivers x·cos θ + y·sin θ with θ = 2π(k+1)/NDIR. All lanes are computed side by side from the same sample, and one lane holds one constant cosine/sine pair and one multiply-add.

A downstream stage that looks for peaks along each direction consumes the lanes. The unit has no control state. A valid flag travels beside the data with the same delay, and the lanes keep refreshing every cycle whether or not the flag is set.

Top module: `bip_proj`

## Requirements
- R1: While reset is held low, `out_valid_o` is 0 and every lane of `proj_o` is 0, whatever the inputs do.
- R2: `out_valid_o` in a given cycle equals `in_valid_i` from exactly two clock edges earlier.
- R3: Lane k (bits k·16 to k·16+15 of `proj_o`) equals floor((x·C_k + y·S_k + 8192) / 16384) for the sample presented two edges earlier. C_k = round(16384·cos(2π(k+1)/NDIR)) and S_k = round(16384·sin(2π(k+1)/NDIR)), with rounding away from zero at halves.
- R4: A lane whose exact rounded result lies outside [-32768, 32767] shows the nearest limit, -32768 or 32767, and never a wrapped value.
- R5: Lane NDIR-1 (angle 2π) reproduces the real input x unchanged.
- R6: With y = 0, every lane equals floor((x·C_k + 8192) / 16384), which is the single-channel case.
- R7: All lanes in a cycle come from the same input sample, and the lanes refresh on every clock whatever the level of `in_valid_i`.
- R8: When NDIR is even, lane NDIR/2-1 (angle π) equals -x, and x = -32768 gives 32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one sample per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Marks the current input sample as meaningful |
| x_i | input | 16 | Real part of the sample, signed |
| y_i | input | 16 | Imaginary part of the sample, signed |
| out_valid_o | output | 1 | `in_valid_i` delayed by two cycles |
| proj_o | output | NDIR·16 (128) | Packed signed projections, lane 0 in the low bits |

## Verification
The bench sweeps every pair from a grid of extreme and near-extreme values and then streams pseudo-random samples with a toggling valid flag, comparing every lane every cycle. A unit that dropped the saturation would show wrapped, sign-flipped values on the 45-degree-family lanes when both inputs are near full scale. A unit that negated by plain two's complement would return -32768 for -x on the half-turn lane. A unit whose rounding truncated instead of adding the half step would be off by one on roughly half of the oblique-lane results. A valid path with the wrong depth, or data gated by valid, shows up as a flag or lane that is out of step with the two-cycle history kept by the bench.

// File: rtl/bip_pkg.sv
`timescale 1ns/1ps
package bip_pkg;

    localparam real BIP_PI = 3.14159265358979323846;
    localparam int  BIP_SERIES_TERMS = 24;

    // Angle of lane k folded into [-pi, pi] so the series converges quickly.
    function automatic real bip_angle(input int k, input int ndir);
        real a;
        a = 2.0 * BIP_PI * real'(k + 1) / real'(ndir);
        if (a > BIP_PI) a = a - 2.0 * BIP_PI;
        return a;
    endfunction

    function automatic real bip_sin_series(input real a);
        real term;
        real acc;
        term = a;
        acc  = a;
        for (int i = 1; i < BIP_SERIES_TERMS; i++) begin
            term = -term * a * a / (real'(2 * i) * real'(2 * i + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    function automatic real bip_cos_series(input real a);
        real term;
        real acc;
        term = 1.0;
        acc  = 1.0;
        for (int i = 1; i < BIP_SERIES_TERMS; i++) begin
            term = -term * a * a / (real'(2 * i - 1) * real'(2 * i));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Scale to fixed point, rounding half away from zero.
    function automatic int bip_quant(input real r, input int frac);
        real scaled;
        scaled = r * real'(64'd1 << frac);
        if (scaled >= 0.0) return $rtoi(scaled + 0.5);
        return -$rtoi(-scaled + 0.5);
    endfunction

    function automatic int bip_coef_cos(input int k, input int ndir, input int frac);
        return bip_quant(bip_cos_series(bip_angle(k, ndir)), frac);
    endfunction

    function automatic int bip_coef_sin(input int k, input int ndir, input int frac);
        return bip_quant(bip_sin_series(bip_angle(k, ndir)), frac);
    endfunction

endpackage

// File: rtl/bip_valid_dly.sv
`timescale 1ns/1ps
module bip_valid_dly #(
    parameter int unsigned DEPTH = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic vld_i,
    output logic vld_o
);

    typedef struct packed {
        logic [DEPTH-1:0] taps;
    } dly_state_t;

    dly_state_t st_d, st_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.taps = vld_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d = st_q;
                st_d.taps = {st_q.taps[DEPTH-2:0], vld_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign vld_o = st_q.taps[DEPTH-1];

endmodule

// File: rtl/bip_lane_mul.sv
`timescale 1ns/1ps
module bip_lane_mul #(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 16,
    parameter logic signed [CW-1:0] COS_C = '0,
    parameter logic signed [CW-1:0] SIN_C = '0
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic signed [DW-1:0]    x_i,
    input  logic signed [DW-1:0]    y_i,
    output logic signed [DW+CW-1:0] px_o,
    output logic signed [DW+CW-1:0] py_o
);

    localparam int unsigned PW = DW + CW;

    typedef struct packed {
        logic [PW-1:0] px;
        logic [PW-1:0] py;
    } mul_state_t;

    mul_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.px = PW'(x_i) * PW'(COS_C);
        st_d.py = PW'(y_i) * PW'(SIN_C);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign px_o = $signed(st_q.px);
    assign py_o = $signed(st_q.py);

endmodule

// File: rtl/bip_lane_sum.sv
`timescale 1ns/1ps
module bip_lane_sum #(
    parameter int unsigned DW   = 16,
    parameter int unsigned PW   = 32,
    parameter int unsigned FRAC = 14
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic signed [PW-1:0] px_i,
    input  logic signed [PW-1:0] py_i,
    output logic signed [DW-1:0] proj_o
);

    localparam int unsigned SW = PW + 1;
    localparam logic signed [SW-1:0] HALF = SW'(1) << (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = (SW'(1) << (DW - 1)) - SW'(1);
    localparam logic signed [SW-1:0] MINV = -(SW'(1) << (DW - 1));

    typedef struct packed {
        logic [DW-1:0] proj;
    } sum_state_t;

    sum_state_t st_d, st_q;

    logic signed [SW-1:0] total;
    logic signed [SW-1:0] scaled;

    always_comb begin
        st_d   = st_q;
        total  = SW'(px_i) + SW'(py_i) + HALF;
        scaled = total >>> FRAC;
        if (scaled > MAXV)      st_d.proj = MAXV[DW-1:0];
        else if (scaled < MINV) st_d.proj = MINV[DW-1:0];
        else                    st_d.proj = scaled[DW-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign proj_o = $signed(st_q.proj);

endmodule

// File: rtl/bip_proj.sv
`timescale 1ns/1ps
module bip_proj #(
    parameter int unsigned NDIR = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned CW   = 16,
    parameter int unsigned FRAC = 14
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 in_valid_i,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic                 out_valid_o,
    output logic [NDIR*DW-1:0]   proj_o
);

    localparam int unsigned PW      = DW + CW;
    localparam int unsigned LATENCY = 2;

    bip_valid_dly #(
        .DEPTH (LATENCY)
    ) u_vld (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .vld_i  (in_valid_i),
        .vld_o  (out_valid_o)
    );

    for (genvar k = 0; k < NDIR; k++) begin : g_lane
        localparam logic signed [CW-1:0] LANE_COS =
            CW'(bip_pkg::bip_coef_cos(k, NDIR, FRAC));
        localparam logic signed [CW-1:0] LANE_SIN =
            CW'(bip_pkg::bip_coef_sin(k, NDIR, FRAC));

        logic signed [PW-1:0] px;
        logic signed [PW-1:0] py;
        logic signed [DW-1:0] lane_out;

        bip_lane_mul #(
            .DW    (DW),
            .CW    (CW),
            .COS_C (LANE_COS),
            .SIN_C (LANE_SIN)
        ) u_mul (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .x_i    (x_i),
            .y_i    (y_i),
            .px_o   (px),
            .py_o   (py)
        );

        bip_lane_sum #(
            .DW   (DW),
            .PW   (PW),
            .FRAC (FRAC)
        ) u_sum (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .px_i   (px),
            .py_i   (py),
            .proj_o (lane_out)
        );

        assign proj_o[k*DW +: DW] = lane_out;
    end

endmodule

// File: rtl/bip_proj_chk.sv
`timescale 1ns/1ps
module bip_proj_chk #(
    parameter int unsigned NDIR = 8,
    parameter int unsigned DW   = 16
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 in_valid_i,
    input logic signed [DW-1:0] x_i,
    input logic signed [DW-1:0] y_i,
    input logic                 out_valid_o,
    input logic [NDIR*DW-1:0]   proj_o
);

    logic [1:0] warm_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    function automatic logic [DW-1:0] neg_sat(input logic [DW-1:0] v);
        logic [DW-1:0] most_neg;
        most_neg = {1'b1, {(DW-1){1'b0}}};
        if (v == most_neg) return ~most_neg;
        return -v;
    endfunction

    assert_valid_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'd2) |-> (out_valid_o == $past(in_valid_i, 2)));

    assert_identity_lane_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'd2) |-> (proj_o[(NDIR-1)*DW +: DW] == $past(x_i, 2)));

    assert_zero_sample_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((warm_q >= 2'd2) && ($past(x_i, 2) == '0) && ($past(y_i, 2) == '0))
        |-> (proj_o == '0));

    if (NDIR % 2 == 0) begin : g_half_turn
        assert_half_turn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (warm_q >= 2'd2) |-> (proj_o[(NDIR/2-1)*DW +: DW] == neg_sat($past(x_i, 2))));
    end

    assert_lanes_refresh_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((warm_q >= 2'd2) && !$past(in_valid_i, 2) && ($past(x_i, 2) != $past(x_i, 3)))
        |-> !$stable(proj_o[(NDIR-1)*DW +: DW]));

endmodule

bind bip_proj bip_proj_chk #(
    .NDIR (NDIR),
    .DW   (DW)
) u_bip_proj_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .x_i         (x_i),
    .y_i         (y_i),
    .out_valid_o (out_valid_o),
    .proj_o      (proj_o)
);

// File: tb/bip_proj_bench.sv
`timescale 1ns/1ps
module bip_proj_bench;

    localparam int NDIR = 8;
    localparam int DW   = 16;
    localparam int FRAC = 14;
    localparam int WATCHDOG_CYCLES = 150000;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic signed [DW-1:0] x_in = '0;
    logic signed [DW-1:0] y_in = '0;
    logic                 out_valid;
    logic [NDIR*DW-1:0]   proj;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    bip_proj #(
        .NDIR (NDIR),
        .DW   (DW),
        .CW   (16),
        .FRAC (FRAC)
    ) u_bip_proj (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .in_valid_i  (in_valid),
        .x_i         (x_in),
        .y_i         (y_in),
        .out_valid_o (out_valid),
        .proj_o      (proj)
    );

    // Coefficients from the requirement formula, using the math library.
    function automatic longint ref_coef(input int k, input bit want_sin);
        real a;
        real r;
        a = 2.0 * 3.14159265358979323846 * real'(k + 1) / real'(NDIR);
        r = (want_sin ? $sin(a) : $cos(a)) * 16384.0;
        if (r >= 0.0) return longint'($rtoi(r + 0.5));
        return -longint'($rtoi(-r + 0.5));
    endfunction

    function automatic longint ref_raw(input int k, input longint x, input longint y);
        longint acc;
        acc = x * ref_coef(k, 1'b0) + y * ref_coef(k, 1'b1) + 64'sd8192;
        return acc >>> FRAC;
    endfunction

    function automatic longint clamp16(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp_v);
        n_checks++;
        if (act != exp_v) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    // Samples driven one and two negedges ago.
    logic signed [DW-1:0] h1_x = '0, h1_y = '0, h2_x = '0, h2_y = '0;
    logic                 h1_v = 1'b0, h2_v = 1'b0;

    task automatic compare_outputs();
        longint raw;
        longint act;
        string  tag;
        check("R2 out_valid", longint'(out_valid), longint'(h2_v));
        for (int k = 0; k < NDIR; k++) begin
            raw = ref_raw(k, longint'(h2_x), longint'(h2_y));
            act = longint'($signed(proj[k*DW +: DW]));
            if (raw != clamp16(raw))        tag = "R4 saturate";
            else if (k == NDIR - 1)         tag = "R5 identity lane";
            else if (k == NDIR / 2 - 1)     tag = "R8 half-turn lane";
            else if (h2_y == 0)             tag = "R6 real-only input";
            else                            tag = "R3/R7 lane value";
            check($sformatf("%s k=%0d x=%0d y=%0d", tag, k, h2_x, h2_y), act, clamp16(raw));
        end
    endtask

    task automatic step(input logic v, input logic signed [DW-1:0] x, input logic signed [DW-1:0] y);
        @(negedge clk);
        compare_outputs();
        h2_x = h1_x; h2_y = h1_y; h2_v = h1_v;
        h1_x = x;    h1_y = y;    h1_v = v;
        in_valid = v; x_in = x; y_in = y;
    endtask

    function automatic logic signed [DW-1:0] grid_val(input int i);
        case (i)
            0:  return -16'sd32768;
            1:  return -16'sd32767;
            2:  return -16'sd23170;
            3:  return -16'sd16384;
            4:  return -16'sd1;
            5:  return 16'sd0;
            6:  return 16'sd1;
            7:  return 16'sd2;
            8:  return 16'sd16383;
            9:  return 16'sd23170;
            10: return 16'sd32766;
            default: return 16'sd32767;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [31:0] lf;
        lf = 32'h1badf00d;

        // R1: outputs held at zero while reset is low, even with live inputs.
        in_valid = 1'b1; x_in = 16'sd12345; y_in = -16'sd4321;
        repeat (4) begin
            @(negedge clk);
            check("R1 reset valid", longint'(out_valid), 0);
            check("R1 reset proj", (proj == '0) ? 0 : 1, 0);
        end
        in_valid = 1'b0; x_in = '0; y_in = '0;
        @(negedge clk);
        rst_n = 1'b1;

        // Grid sweep over corner values, valid pattern alternating.
        for (int i = 0; i < 12; i++) begin
            for (int j = 0; j < 12; j++) begin
                step(((i + j) % 3) != 0, grid_val(i), grid_val(j));
            end
        end

        // R6: real-only sweep over a ramp.
        for (int i = -32768; i < 32768; i += 997) begin
            step(1'b1, DW'(i), '0);
        end

        // R7: streaming pseudo-random samples with random valid.
        for (int n = 0; n < 3000; n++) begin
            lf = lf ^ (lf << 13);
            lf = lf ^ (lf >> 17);
            lf = lf ^ (lf << 5);
            step(lf[31], lf[15:0], lf[30:15]);
        end

        // Drain the pipeline.
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule